// File: doc/BRIEF.md
# Four-Bit-per-Cycle Leap-Ahead Pseudo-Random Word Generator

This block produces a stream of uniformly distributed 4-bit unsigned words, one per clock with no gaps, from an 18-stage maximal-length shift register. Each clock advances the register by four single shift steps at once. The four-step transition is a fixed XOR network, derived when the design is elaborated by raising the one-step companion matrix to the fourth power over GF(2). The block contains only flip-flops and XOR gates.

Every instance takes its seed from a module parameter. Many copies can therefore run side by side with uncorrelated streams, for example as the inputs of an adder tree that shapes the distribution further downstream. A synchronous reset loads the seed. The all-zero state would lock the register, so a zero seed is replaced by the value 1.

Top module: `lfsr_leap4_top`

## Requirements
- R1: While `srst` is high at a rising clock edge, the state register loads the seed. In the cycle that follows, `sample` shows the look-ahead word of the seed.
- R2: When the seed parameter is zero, reset loads the value 18'h00001 instead.
- R3: With `srst` low, each rising edge replaces the state with the result of four single steps. In a single step on state s[17:0], the new bit is s[17] XOR s[10] (polynomial x^18 + x^11 + 1), the register shifts up by one, and the new bit enters at bit 0.
- R4: `sample` holds the four bits that the next four single steps shift in. The earliest of them is in bit 3 and the latest in bit 0, so `sample` equals bits [3:0] of the next state.
- R5: A new, valid word appears on `sample` in every cycle from the first cycle after reset, with no stall cycles.
- R6: The single-step sequence has period 2^18 − 1, and the state is never all zeros after a reset.
- R7: Holding `srst` high for several cycles keeps the state at the seed. Asserting it in the middle of a run restarts the sequence from the seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| srst | input | 1 | Synchronous active-high reset; loads the seed |
| sample | output | STEPS (4) | Unsigned pseudo-random word for this cycle |

## Verification
The properties assume that `srst` has been sampled high at least once, because the state is undefined before that. Each check therefore waits until a reset has been seen. Before that point, the stimulus keeps `srst` high from time zero through the first clock edges, so the state is defined before any check applies. The scoreboard's reference advances one bit at a time, four times per cycle. It gives the same result for any seed, so one instance with a nonzero seed and one with a zero seed cover the seed-loading paths.

// File: rtl/lfsr_leap_pkg.sv
package lfsr_leap_pkg;

    localparam int MAX_WIDTH = 64;

    // Replace an all-zero seed (within the low w bits) by 1 so the register cannot lock.
    function automatic logic [MAX_WIDTH-1:0] seed_or_default(
        input logic [MAX_WIDTH-1:0] seed,
        input int                   w
    );
        logic [MAX_WIDTH-1:0] keep;
        logic [MAX_WIDTH-1:0] trimmed;
        keep    = (w >= MAX_WIDTH) ? '1 : ((64'd1 << w) - 64'd1);
        trimmed = seed & keep;
        return (trimmed == '0) ? 64'd1 : trimmed;
    endfunction

endpackage

// File: rtl/lfsr_xor_matrix.sv
module lfsr_xor_matrix #(
    parameter int W     = 18,
    parameter int TAP   = 11,
    parameter int STEPS = 4
) (
    input  logic [W-1:0] cur_state,
    output logic [W-1:0] nxt_state
);

    typedef logic [W-1:0][W-1:0] mask_arr_t;

    // Row j of the result lists the current-state bits whose XOR gives next bit j.
    function automatic mask_arr_t build_masks();
        mask_arr_t    m;
        logic [W-1:0] fb;
        for (int i = 0; i < W; i++) begin
            m[i]    = '0;
            m[i][i] = 1'b1;
        end
        for (int s = 0; s < STEPS; s++) begin
            fb = m[W-1] ^ m[TAP-1];
            for (int i = W - 1; i > 0; i--) begin
                m[i] = m[i-1];
            end
            m[0] = fb;
        end
        return m;
    endfunction

    localparam mask_arr_t MASKS = build_masks();

    for (genvar j = 0; j < W; j++) begin : g_row
        assign nxt_state[j] = ^(cur_state & MASKS[j]);
    end

endmodule

// File: rtl/lfsr_state_reg.sv
module lfsr_state_reg #(
    parameter int           W    = 18,
    parameter logic [W-1:0] LOAD = 18'h00001
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] nxt_state,
    output logic [W-1:0] state_q
);

    always_ff @(posedge clk) begin
        if (srst) begin
            state_q <= LOAD;
        end else begin
            state_q <= nxt_state;
        end
    end

endmodule

// File: rtl/lfsr_leap4_top.sv
module lfsr_leap4_top #(
    parameter int           W     = 18,
    parameter int           TAP   = 11,
    parameter int           STEPS = 4,
    parameter logic [W-1:0] SEED  = 18'h1D2A3
) (
    input  logic             clk,
    input  logic             srst,
    output logic [STEPS-1:0] sample
);

    localparam logic [lfsr_leap_pkg::MAX_WIDTH-1:0] LOAD_WIDE =
        lfsr_leap_pkg::seed_or_default(lfsr_leap_pkg::MAX_WIDTH'(SEED), W);
    localparam logic [W-1:0] LOAD_VALUE = LOAD_WIDE[W-1:0];

    logic [W-1:0] state_q;
    logic [W-1:0] nxt_state;

    lfsr_xor_matrix #(
        .W     (W),
        .TAP   (TAP),
        .STEPS (STEPS)
    ) u_matrix (
        .cur_state (state_q),
        .nxt_state (nxt_state)
    );

    lfsr_state_reg #(
        .W    (W),
        .LOAD (LOAD_VALUE)
    ) u_state (
        .clk       (clk),
        .srst      (srst),
        .nxt_state (nxt_state),
        .state_q   (state_q)
    );

    // Newest STEPS bits of the look-ahead state, earliest in the top position.
    assign sample = nxt_state[STEPS-1:0];

endmodule

// File: rtl/lfsr_leap4_chk.sv
module lfsr_leap4_chk #(
    parameter int W     = 18,
    parameter int STEPS = 4
) (
    input logic             clk,
    input logic             srst,
    input logic [W-1:0]     state,
    input logic [STEPS-1:0] sample,
    input logic [W-1:0]     seed_value
);

    logic armed = 1'b0;

    always_ff @(posedge clk) begin
        if (srst) begin
            armed <= 1'b1;
        end
    end

    // R1
    seed_load_chk: assert property (@(posedge clk)
        srst |=> state == seed_value);

    // R3
    shift_up_chk: assert property (@(posedge clk) disable iff (srst || !armed)
        1'b1 |=> state[W-1:STEPS] == $past(state[W-1-STEPS:0]));

    // R4
    sample_lands_chk: assert property (@(posedge clk) disable iff (srst || !armed)
        1'b1 |=> state[STEPS-1:0] == $past(sample));

    // R6
    never_zero_chk: assert property (@(posedge clk) disable iff (srst || !armed)
        state != '0);

endmodule

bind lfsr_leap4_top lfsr_leap4_chk #(
    .W     (W),
    .STEPS (STEPS)
) u_chk (
    .clk        (clk),
    .srst       (srst),
    .state      (state_q),
    .sample     (sample),
    .seed_value (LOAD_VALUE)
);

// File: tb/tb_lfsr_leap4_top.sv
module tb_lfsr_leap4_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          PERIOD     = (1 << 18) - 1;
    localparam logic [17:0] SEED_A     = 18'h2B5C7;
    localparam logic [17:0] SEED_Z     = 18'h00001;

    logic       clk  = 1'b0;
    logic       srst = 1'b1;
    logic [3:0] sample_a;
    logic [3:0] sample_z;

    int tests = 0;
    int fails = 0;

    logic [17:0] ref_a;
    logic [17:0] ref_z;
    logic [7:0]  exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    lfsr_leap4_top #(.SEED(SEED_A)) dut   (.clk(clk), .srst(srst), .sample(sample_a));
    lfsr_leap4_top #(.SEED(18'h0))  dut_z (.clk(clk), .srst(srst), .sample(sample_z));

    function automatic logic [17:0] one_step(input logic [17:0] s);
        return {s[16:0], s[17] ^ s[10]};
    endfunction

    function automatic logic [17:0] four_steps(input logic [17:0] s);
        logic [17:0] t = s;
        for (int k = 0; k < 4; k++) t = one_step(t);
        return t;
    endfunction

    function automatic logic [3:0] next_word(input logic [17:0] s);
        logic [17:0] t = s;
        logic [3:0]  w;
        for (int k = 0; k < 4; k++) begin
            t        = one_step(t);
            w[3 - k] = t[0];
        end
        return w;
    endfunction

    task automatic push_expected(input string tag);
        exp_q.push_back({next_word(ref_a), next_word(ref_z)});
        tag_q.push_back(tag);
    endtask

    task automatic do_reset(input int hold, input string tag);
        @(negedge clk);
        srst = 1'b1;
        repeat (hold) begin
            @(posedge clk);
            #1;
            ref_a = SEED_A;
            ref_z = SEED_Z;
            push_expected(tag);
        end
        @(negedge clk);
        srst = 1'b0;
    endtask

    task automatic run_cycles(input int n, input string tag);
        repeat (n) begin
            @(posedge clk);
            #1;
            ref_a = four_steps(ref_a);
            ref_z = four_steps(ref_z);
            push_expected(tag);
        end
    endtask

    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            logic [7:0] e;
            string      t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            tests++;
            if (sample_a !== e[7:4]) begin
                fails++;
                $display("FAIL %s: sample actual %h expected %h", t, sample_a, e[7:4]);
            end
            tests++;
            if (sample_z !== e[3:0]) begin
                fails++;
                $display("FAIL R2 (%s): zero-seed sample actual %h expected %h", t, sample_z, e[3:0]);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int          first_back;
        logic        hit_zero;
        logic [17:0] s;

        // R1: reset state and first word after reset
        do_reset(1, "R1");
        // R4 / R3: look-ahead word and four-step advance
        run_cycles(50, "R4");
        run_cycles(2000, "R3");
        // R7: reset held for several cycles, then restart mid-run
        do_reset(4, "R7");
        run_cycles(300, "R7");
        do_reset(1, "R7");
        // R5: continuous words every cycle over a long run
        run_cycles(3000, "R5");
        @(negedge clk);
        @(negedge clk);

        // R6: period of the single-step sequence and absence of the zero state
        s          = SEED_A;
        first_back = 0;
        hit_zero   = 1'b0;
        for (int i = 1; i <= PERIOD; i++) begin
            s = one_step(s);
            if (s == 18'h0) hit_zero = 1'b1;
            if (s == SEED_A && first_back == 0) first_back = i;
        end
        tests++;
        if (first_back != PERIOD) begin
            fails++;
            $display("FAIL R6: period actual %0d expected %0d", first_back, PERIOD);
        end
        tests++;
        if (hit_zero) begin
            fails++;
            $display("FAIL R6: zero state actual 1 expected 0");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule